// File: doc/BRIEF.md
# Reorder Buffer With Precise Commit

This block is the in-order retirement queue of a small out-of-order core. At rename each instruction claims the next free slot of a six-slot circular buffer and receives that slot number as its tag. The tag then serves as the temporary name of the instruction's result. Execution units return results in any order against those tags. The buffer stores each result in its slot and broadcasts the tag on the same cycle, so that waiting instructions can mark their operands ready. Results reach the 32-entry architectural register file only when their slot retires from the head, at most one per cycle.

Two events break the normal flow. An instruction that completes with an exception does nothing until it becomes the oldest entry. At that point the block reports its PC and empties itself. The register file then holds the results of every older instruction and of nothing younger. A branch that completes as mispredicted discards every younger slot at once and moves the allocation point to the slot just after the branch. The branch itself stays in the buffer and retires normally.

Occupancy is tracked by a three-state machine. OCC_EMPTY holds no entries. OCC_PARTIAL holds one to five. OCC_FULL holds all six and stalls allocation. Its transitions are: fill (EMPTY to PARTIAL on the first allocation), top-off (PARTIAL to FULL), drain-one (FULL to PARTIAL on a retirement or a flush), drain-last (PARTIAL to EMPTY), and trap-clear (any state to EMPTY on an exception report).

Top module: `rob_top`

## Requirements
- R1: An accepted allocation receives the tag shown on `alloc_tag`, which is the slot number. Tags run 0,1,2,3,4,5 and then wrap back to 0.
- R2: With six entries in use, `full` is 1 and `alloc_ready` is 0, so `alloc_valid` has no effect. With fewer than six, and no exception or flush in that cycle, `alloc_ready` is 1.
- R3: A completion whose tag names a live slot that has not yet completed raises `bcast_valid` with that tag in the same cycle. A completion whose tag is 6 or 7, names a free or flushed slot, or names a slot that already completed is ignored and produces no broadcast.
- R4: The oldest entry retires in the cycle after its completion at the earliest, one entry per cycle, in allocation order. For an entry with a destination, `rf_we` is 1 with its register number and result. No younger entry retires before an older one.
- R5: An entry allocated with `alloc_has_dst`=0 retires without raising `rf_we`, and the next entry becomes the head.
- R6: When the oldest entry has completed with the exception flag set, `exc_valid` is 1 with that entry's PC and `rf_we` is 0. Every older entry has already retired. The buffer then empties, and the next tag issued is 0.
- R7: A completion that carries the mispredict flag raises `flush_valid` with the branch tag in that cycle, and `alloc_ready` is 0 in that cycle. Every younger entry is discarded and never retires. The next tag issued is the branch tag plus one, modulo 6.
- R8: In a cycle that reports an exception, any completion is ignored and no allocation is accepted.
- R9: After reset the buffer is empty: `alloc_ready`=1, `full`=0, `alloc_tag`=0, and no broadcast, write, exception or flush is signalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| alloc_valid | input | 1 | Rename offers an instruction |
| alloc_pc | input | 32 | PC of the offered instruction |
| alloc_has_dst | input | 1 | Instruction writes a register |
| alloc_dst | input | 5 | Destination register number |
| alloc_ready | output | 1 | Allocation accepted this cycle if offered |
| alloc_tag | output | 3 | Tag given to the offered instruction |
| full | output | 1 | All six slots in use |
| cmp_valid | input | 1 | An execution unit reports a completion |
| cmp_tag | input | 3 | Tag of the completing instruction |
| cmp_value | input | 32 | Result value |
| cmp_exc | input | 1 | Instruction raised an exception |
| cmp_mispredict | input | 1 | Branch was mispredicted |
| bcast_valid | output | 1 | Tag broadcast is valid |
| bcast_tag | output | 3 | Tag whose result is now available |
| rf_we | output | 1 | Architectural register write at retirement |
| rf_waddr | output | 5 | Register written |
| rf_wdata | output | 32 | Value written |
| exc_valid | output | 1 | Exception taken at the head |
| exc_pc | output | 32 | PC of the excepting instruction |
| flush_valid | output | 1 | Younger entries discarded |
| flush_tag | output | 3 | Tag of the mispredicted branch |

## Verification
The hardest state to reach from the ports is an exception becoming the head while a mispredict flush, a retirement or an allocation is offered in the same cycle, especially with the buffer full and the pointers wrapped. Directed sequences first build each of these cases alone: a completion out of order, a slot with no destination, a flush in mid-buffer followed by a completion against a discarded tag, and an exception held back behind older entries while an allocation and a completion are offered. A long run of random traffic with rare exception and mispredict flags then drives the buffer repeatedly through full, wrap and clear. A queue-based model in the bench predicts every output on every cycle.

// File: rtl/rob_pkg.sv
package rob_pkg;

    localparam int ROB_SLOTS = 6;
    localparam int ARCH_REGS = 32;
    localparam int WORD_W    = 32;
    localparam int ADDR_W    = 32;

    typedef enum logic [1:0] {
        OCC_EMPTY   = 2'd0,
        OCC_PARTIAL = 2'd1,
        OCC_FULL    = 2'd2
    } occ_state_e;

endpackage

// File: rtl/rob_entries.sv
module rob_entries #(
    parameter int DEPTH  = 6,
    parameter int TAG_W  = 3,
    parameter int DATA_W = 32,
    parameter int PC_W   = 32,
    parameter int REG_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_we,
    input  logic [TAG_W-1:0]  alloc_idx,
    input  logic [PC_W-1:0]   alloc_pc,
    input  logic              alloc_has_dst,
    input  logic [REG_W-1:0]  alloc_dst,
    input  logic              cmp_we,
    input  logic [TAG_W-1:0]  cmp_idx,
    input  logic [DATA_W-1:0] cmp_value,
    input  logic              cmp_exc,
    input  logic [DEPTH-1:0]  kill,
    input  logic [TAG_W-1:0]  rd_idx,
    output logic [DEPTH-1:0]  valid_vec,
    output logic [DEPTH-1:0]  done_vec,
    output logic [PC_W-1:0]   rd_pc,
    output logic              rd_has_dst,
    output logic [REG_W-1:0]  rd_dst,
    output logic [DATA_W-1:0] rd_value,
    output logic              rd_exc
);

    logic              valid_q   [DEPTH];
    logic              done_q    [DEPTH];
    logic [PC_W-1:0]   pc_q      [DEPTH];
    logic              hasdst_q  [DEPTH];
    logic [REG_W-1:0]  dst_q     [DEPTH];
    logic [DATA_W-1:0] value_q   [DEPTH];
    logic              exc_q     [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        // Slot lifecycle: kill wins, then a fresh claim, then a completion.
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                valid_q[g]  <= 1'b0;
                done_q[g]   <= 1'b0;
                pc_q[g]     <= '0;
                hasdst_q[g] <= 1'b0;
                dst_q[g]    <= '0;
                value_q[g]  <= '0;
                exc_q[g]    <= 1'b0;
            end else if (kill[g]) begin
                valid_q[g] <= 1'b0;
                done_q[g]  <= 1'b0;
            end else if (alloc_we && alloc_idx == TAG_W'(g)) begin
                valid_q[g]  <= 1'b1;
                done_q[g]   <= 1'b0;
                exc_q[g]    <= 1'b0;
                pc_q[g]     <= alloc_pc;
                hasdst_q[g] <= alloc_has_dst;
                dst_q[g]    <= alloc_dst;
            end else if (cmp_we && cmp_idx == TAG_W'(g)) begin
                done_q[g]  <= 1'b1;
                value_q[g] <= cmp_value;
                exc_q[g]   <= cmp_exc;
            end
        end

        assign valid_vec[g] = valid_q[g];
        assign done_vec[g]  = done_q[g];

        // R3: a slot only becomes complete through an accepted completion
        p_done_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (done_q[g] && !$past(done_q[g])) |-> $past(cmp_we && cmp_idx == TAG_W'(g)));

        // R4: a completed slot stays live until it is killed
        p_done_live_r4: assert property (@(posedge clk) disable iff (!rst_n)
            done_q[g] |-> valid_q[g]);
    end

    assign rd_pc      = pc_q[rd_idx];
    assign rd_has_dst = hasdst_q[rd_idx];
    assign rd_dst     = dst_q[rd_idx];
    assign rd_value   = value_q[rd_idx];
    assign rd_exc     = exc_q[rd_idx];

endmodule

// File: rtl/rob_ctrl.sv
module rob_ctrl
    import rob_pkg::*;
#(
    parameter int DEPTH = 6,
    parameter int TAG_W = 3,
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_valid,
    input  logic             cmp_valid,
    input  logic [TAG_W-1:0] cmp_tag,
    input  logic             cmp_mispredict,
    input  logic [DEPTH-1:0] valid_vec,
    input  logic [DEPTH-1:0] done_vec,
    input  logic             head_exc,
    output logic [TAG_W-1:0] head,
    output logic [TAG_W-1:0] tail,
    output logic             alloc_ready,
    output logic             full,
    output logic             alloc_fire,
    output logic             cmp_fire,
    output logic             flush_fire,
    output logic             commit_fire,
    output logic             exc_fire,
    output logic [DEPTH-1:0] kill
);

    localparam logic [TAG_W-1:0] LAST_SLOT = TAG_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CAP       = CNT_W'(DEPTH);

    function automatic logic [TAG_W-1:0] wrap_inc(input logic [TAG_W-1:0] p);
        return (p == LAST_SLOT) ? '0 : p + 1'b1;
    endfunction

    function automatic logic [TAG_W-1:0] age_of(input logic [TAG_W-1:0] idx,
                                                input logic [TAG_W-1:0] hd);
        if (idx >= hd) return idx - hd;
        else           return TAG_W'(idx + TAG_W'(DEPTH) - hd);
    endfunction

    occ_state_e       state_q, state_d;
    logic [TAG_W-1:0] head_q, head_d, tail_q, tail_d;
    logic [CNT_W-1:0] count_q, count_d;
    logic             tag_in_range, tag_live, tag_done, head_ready;

    // State register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= OCC_EMPTY;
            head_q  <= '0;
            tail_q  <= '0;
            count_q <= '0;
        end else begin
            state_q <= state_d;
            head_q  <= head_d;
            tail_q  <= tail_d;
            count_q <= count_d;
        end
    end

    // Event decode
    always_comb begin
        tag_in_range = (cmp_tag <= LAST_SLOT);
        tag_live     = tag_in_range && valid_vec[cmp_tag];
        tag_done     = tag_in_range && done_vec[cmp_tag];
        head_ready   = valid_vec[head_q] && done_vec[head_q];
        exc_fire     = head_ready && head_exc;
        commit_fire  = head_ready && !head_exc;
        cmp_fire     = cmp_valid && tag_live && !tag_done && !exc_fire;
        flush_fire   = cmp_fire && cmp_mispredict;
    end

    // Next pointers, count and occupancy state
    always_comb begin
        head_d  = head_q;
        tail_d  = tail_q;
        count_d = count_q;
        if (exc_fire) begin
            head_d  = '0;
            tail_d  = '0;
            count_d = '0;
        end else begin
            if (commit_fire) head_d = wrap_inc(head_q);
            if (flush_fire) begin
                tail_d  = wrap_inc(cmp_tag);
                count_d = CNT_W'(age_of(cmp_tag, head_q)) + CNT_W'(1)
                        - CNT_W'(commit_fire);
            end else begin
                if (alloc_fire) tail_d = wrap_inc(tail_q);
                count_d = count_q + CNT_W'(alloc_fire) - CNT_W'(commit_fire);
            end
        end

        state_d = state_q;
        if (exc_fire) begin
            state_d = OCC_EMPTY;                       // trap-clear
        end else begin
            unique case (state_q)
                OCC_EMPTY:
                    if (count_d != '0) state_d = OCC_PARTIAL;      // fill
                OCC_PARTIAL:
                    if (count_d == '0)       state_d = OCC_EMPTY;  // drain-last
                    else if (count_d == CAP) state_d = OCC_FULL;   // top-off
                OCC_FULL:
                    if (count_d == '0)        state_d = OCC_EMPTY;
                    else if (count_d != CAP)  state_d = OCC_PARTIAL; // drain-one
                default: state_d = OCC_EMPTY;
            endcase
        end
    end

    // Output process
    always_comb begin
        full        = (state_q == OCC_FULL);
        alloc_ready = !full && !exc_fire && !flush_fire;
        alloc_fire  = alloc_valid && alloc_ready;
        head        = head_q;
        tail        = tail_q;
        for (int i = 0; i < DEPTH; i++) begin
            kill[i] = exc_fire
                   || (commit_fire && head_q == TAG_W'(i))
                   || (flush_fire && valid_vec[i]
                       && age_of(TAG_W'(i), head_q) > age_of(cmp_tag, head_q));
        end
    end

    // R2: occupancy never exceeds the slot count
    p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CAP);

    // R2: a full buffer stays full without a retirement, flush or trap
    p_full_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !commit_fire && !exc_fire && !flush_fire) |=> full);

    // R4: each retirement advances the head by exactly one slot
    p_head_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        commit_fire |=> head_q == wrap_inc($past(head_q)));

    // R6: an exception report leaves the buffer empty at slot zero
    p_trap_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        exc_fire |=> (state_q == OCC_EMPTY && head_q == '0 && tail_q == '0));

    // R7: a flush reopens allocation right after the branch
    p_flush_tail_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flush_fire |=> tail_q == wrap_inc($past(cmp_tag)));

    // R8: no allocation or completion accepted while trapping
    p_trap_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
        exc_fire |-> (!alloc_fire && !cmp_fire));

endmodule

// File: rtl/rob_top.sv
module rob_top
    import rob_pkg::*;
#(
    parameter int DEPTH     = ROB_SLOTS,
    parameter int NUM_REGS  = ARCH_REGS,
    parameter int DATA_W    = WORD_W,
    parameter int PC_W      = ADDR_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          alloc_valid,
    input  logic [PC_W-1:0]               alloc_pc,
    input  logic                          alloc_has_dst,
    input  logic [$clog2(NUM_REGS)-1:0]   alloc_dst,
    output logic                          alloc_ready,
    output logic [$clog2(DEPTH)-1:0]      alloc_tag,
    output logic                          full,
    input  logic                          cmp_valid,
    input  logic [$clog2(DEPTH)-1:0]      cmp_tag,
    input  logic [DATA_W-1:0]             cmp_value,
    input  logic                          cmp_exc,
    input  logic                          cmp_mispredict,
    output logic                          bcast_valid,
    output logic [$clog2(DEPTH)-1:0]      bcast_tag,
    output logic                          rf_we,
    output logic [$clog2(NUM_REGS)-1:0]   rf_waddr,
    output logic [DATA_W-1:0]             rf_wdata,
    output logic                          exc_valid,
    output logic [PC_W-1:0]               exc_pc,
    output logic                          flush_valid,
    output logic [$clog2(DEPTH)-1:0]      flush_tag
);

    localparam int TAG_W = $clog2(DEPTH);
    localparam int REG_W = $clog2(NUM_REGS);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [TAG_W-1:0]  head, tail;
    logic              alloc_fire, cmp_fire, flush_fire, commit_fire, exc_fire;
    logic [DEPTH-1:0]  kill, valid_vec, done_vec;
    logic [PC_W-1:0]   head_pc;
    logic              head_has_dst, head_exc;
    logic [REG_W-1:0]  head_dst;
    logic [DATA_W-1:0] head_value;

    rob_ctrl #(.DEPTH(DEPTH), .TAG_W(TAG_W), .CNT_W(CNT_W)) u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .alloc_valid    (alloc_valid),
        .cmp_valid      (cmp_valid),
        .cmp_tag        (cmp_tag),
        .cmp_mispredict (cmp_mispredict),
        .valid_vec      (valid_vec),
        .done_vec       (done_vec),
        .head_exc       (head_exc),
        .head           (head),
        .tail           (tail),
        .alloc_ready    (alloc_ready),
        .full           (full),
        .alloc_fire     (alloc_fire),
        .cmp_fire       (cmp_fire),
        .flush_fire     (flush_fire),
        .commit_fire    (commit_fire),
        .exc_fire       (exc_fire),
        .kill           (kill)
    );

    rob_entries #(.DEPTH(DEPTH), .TAG_W(TAG_W), .DATA_W(DATA_W),
                  .PC_W(PC_W), .REG_W(REG_W)) u_entries (
        .clk           (clk),
        .rst_n         (rst_n),
        .alloc_we      (alloc_fire),
        .alloc_idx     (tail),
        .alloc_pc      (alloc_pc),
        .alloc_has_dst (alloc_has_dst),
        .alloc_dst     (alloc_dst),
        .cmp_we        (cmp_fire),
        .cmp_idx       (cmp_tag),
        .cmp_value     (cmp_value),
        .cmp_exc       (cmp_exc),
        .kill          (kill),
        .rd_idx        (head),
        .valid_vec     (valid_vec),
        .done_vec      (done_vec),
        .rd_pc         (head_pc),
        .rd_has_dst    (head_has_dst),
        .rd_dst        (head_dst),
        .rd_value      (head_value),
        .rd_exc        (head_exc)
    );

    always_comb begin
        alloc_tag   = tail;
        bcast_valid = cmp_fire;
        bcast_tag   = cmp_tag;
        rf_we       = commit_fire && head_has_dst;
        rf_waddr    = head_dst;
        rf_wdata    = head_value;
        exc_valid   = exc_fire;
        exc_pc      = head_pc;
        flush_valid = flush_fire;
        flush_tag   = cmp_tag;
    end

    // R6: a trap never coincides with a register write
    p_trap_no_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |-> !rf_we);

    // R3: a broadcast tag has completed in the following cycle
    p_bcast_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bcast_valid |=> done_vec[$past(bcast_tag)]);

endmodule

// File: tb/sim_rob_top.sv
module sim_rob_top;

    localparam int PERIOD = 10;
    localparam int SLOTS  = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        alloc_valid = 1'b0;
    logic [31:0] alloc_pc = '0;
    logic        alloc_has_dst = 1'b0;
    logic [4:0]  alloc_dst = '0;
    logic        alloc_ready;
    logic [2:0]  alloc_tag;
    logic        full;
    logic        cmp_valid = 1'b0;
    logic [2:0]  cmp_tag = '0;
    logic [31:0] cmp_value = '0;
    logic        cmp_exc = 1'b0;
    logic        cmp_mispredict = 1'b0;
    logic        bcast_valid;
    logic [2:0]  bcast_tag;
    logic        rf_we;
    logic [4:0]  rf_waddr;
    logic [31:0] rf_wdata;
    logic        exc_valid;
    logic [31:0] exc_pc;
    logic        flush_valid;
    logic [2:0]  flush_tag;

    always #(PERIOD/2) clk = ~clk;

    rob_top u0 (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_pc(alloc_pc),
        .alloc_has_dst(alloc_has_dst), .alloc_dst(alloc_dst),
        .alloc_ready(alloc_ready), .alloc_tag(alloc_tag), .full(full),
        .cmp_valid(cmp_valid), .cmp_tag(cmp_tag), .cmp_value(cmp_value),
        .cmp_exc(cmp_exc), .cmp_mispredict(cmp_mispredict),
        .bcast_valid(bcast_valid), .bcast_tag(bcast_tag),
        .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
        .exc_valid(exc_valid), .exc_pc(exc_pc),
        .flush_valid(flush_valid), .flush_tag(flush_tag)
    );

    typedef struct {
        int          tag;
        logic [31:0] pc;
        bit          has_dst;
        int          dst;
        bit          done;
        logic [31:0] value;
        bit          exc;
    } ent_t;

    ent_t q[$];
    int   next_tag = 0;
    int   checks = 0;
    int   errors = 0;
    bit   finished = 0;

    // expected values of the current cycle
    bit e_exc, e_com, e_ok, e_flush, e_ready;
    int e_k;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic predict();
        e_exc = 0; e_com = 0; e_ok = 0; e_flush = 0; e_k = -1;
        if (q.size() > 0 && q[0].done) begin
            e_exc = q[0].exc;
            e_com = !q[0].exc;
        end
        foreach (q[i]) if (q[i].tag == int'(cmp_tag)) e_k = i;
        e_ok    = cmp_valid && e_k >= 0 && !e_exc;
        if (e_ok && q[e_k].done) e_ok = 0;
        e_flush = e_ok && cmp_mispredict;
        e_ready = q.size() < SLOTS && !e_exc && !e_flush;
    endtask

    task automatic compare();
        bit e_we;
        predict();
        e_we = e_com && q[0].has_dst;
        chk(alloc_tag == 3'(next_tag), "R1", "alloc_tag", 32'(alloc_tag), 32'(next_tag));
        chk(alloc_ready == e_ready, "R2", "alloc_ready", 32'(alloc_ready), 32'(e_ready));
        chk(full == (q.size() == SLOTS), "R2", "full", 32'(full), 32'(q.size() == SLOTS));
        chk(bcast_valid == e_ok, "R3", "bcast_valid", 32'(bcast_valid), 32'(e_ok));
        if (e_ok) chk(bcast_tag == cmp_tag, "R3", "bcast_tag", 32'(bcast_tag), 32'(cmp_tag));
        chk(rf_we == e_we, "R4", "rf_we", 32'(rf_we), 32'(e_we));
        if (e_com && !q[0].has_dst)
            chk(!rf_we, "R5", "rf_we without dst", 32'(rf_we), 0);
        if (e_we) begin
            chk(rf_waddr == 5'(q[0].dst), "R4", "rf_waddr", 32'(rf_waddr), 32'(q[0].dst));
            chk(rf_wdata == q[0].value, "R4", "rf_wdata", rf_wdata, q[0].value);
        end
        chk(exc_valid == e_exc, "R6", "exc_valid", 32'(exc_valid), 32'(e_exc));
        if (e_exc) begin
            chk(exc_pc == q[0].pc, "R6", "exc_pc", exc_pc, q[0].pc);
            chk(!bcast_valid, "R8", "bcast during trap", 32'(bcast_valid), 0);
            chk(!alloc_ready, "R8", "alloc_ready during trap", 32'(alloc_ready), 0);
        end
        chk(flush_valid == e_flush, "R7", "flush_valid", 32'(flush_valid), 32'(e_flush));
        if (e_flush) chk(flush_tag == cmp_tag, "R7", "flush_tag", 32'(flush_tag), 32'(cmp_tag));
    endtask

    task automatic update();
        ent_t n;
        if (e_exc) begin
            q.delete();
            next_tag = 0;
            return;
        end
        if (e_ok) begin
            q[e_k].done  = 1;
            q[e_k].value = cmp_value;
            q[e_k].exc   = cmp_exc;
            if (e_flush) begin
                while (q.size() > e_k + 1) void'(q.pop_back());
                next_tag = (int'(cmp_tag) + 1) % SLOTS;
            end
        end
        if (e_com) void'(q.pop_front());
        if (alloc_valid && e_ready) begin
            n.tag = next_tag; n.pc = alloc_pc; n.has_dst = alloc_has_dst;
            n.dst = int'(alloc_dst); n.done = 0; n.value = '0; n.exc = 0;
            q.push_back(n);
            next_tag = (next_tag + 1) % SLOTS;
        end
    endtask

    task automatic cycle();
        #1;
        compare();
        @(posedge clk);
        update();
        @(negedge clk);
    endtask

    task automatic idle();
        alloc_valid = 0; cmp_valid = 0; cmp_exc = 0; cmp_mispredict = 0;
    endtask

    task automatic do_alloc(input logic [31:0] pc, input bit hd, input int dst);
        idle();
        alloc_valid = 1; alloc_pc = pc; alloc_has_dst = hd; alloc_dst = 5'(dst);
        cycle();
    endtask

    task automatic do_cmp(input int tag, input logic [31:0] val, input bit ex, input bit mp);
        idle();
        cmp_valid = 1; cmp_tag = 3'(tag); cmp_value = val; cmp_exc = ex; cmp_mispredict = mp;
        cycle();
    endtask

    task automatic do_idle(input int n);
        for (int i = 0; i < n; i++) begin idle(); cycle(); end
    endtask

    initial begin
        #(PERIOD * 200000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        idle();
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        // R9: reset state at the ports
        chk(alloc_ready == 1, "R9", "alloc_ready after reset", 32'(alloc_ready), 1);
        chk(full == 0, "R9", "full after reset", 32'(full), 0);
        chk(alloc_tag == 0, "R9", "alloc_tag after reset", 32'(alloc_tag), 0);
        chk(!bcast_valid && !rf_we && !exc_valid && !flush_valid, "R9",
            "idle outputs after reset", 32'({bcast_valid, rf_we, exc_valid, flush_valid}), 0);
        @(negedge clk);

        // R1, R2: fill to six, seventh offer stalls; slot 1 has no destination (R5)
        for (int i = 0; i < 7; i++) do_alloc(32'h100 + 32'(4*i), i != 1, 3 + i);
        // R3: out-of-order completions, plus an out-of-range tag
        do_cmp(2, 32'hA2, 0, 0);
        do_cmp(7, 32'hFF, 0, 0);
        do_cmp(0, 32'hA0, 0, 0);
        do_cmp(0, 32'hBB, 0, 0);      // R3: repeat after completion is ignored
        do_cmp(1, 32'hA1, 0, 0);      // R5: no-destination slot retires silently
        do_idle(3);                   // R4: in-order retirement
        do_alloc(32'h200, 1, 9);      // R1: tag wraps through the slots
        do_alloc(32'h204, 1, 10);

        // R7: mispredict in the middle
        do_cmp(4, 32'hC4, 0, 1);
        do_cmp(5, 32'hC5, 0, 0);      // flushed tag, ignored
        do_alloc(32'h300, 1, 11);
        do_cmp(3, 32'hC3, 0, 0);
        do_idle(3);

        // R6, R8: younger exception waits for older; trap cycle sees alloc + cmp offers
        do_alloc(32'h400, 1, 12);
        do_alloc(32'h404, 1, 13);
        do_alloc(32'h408, 1, 14);
        begin
            int t0, t1, t2;
            t0 = q.size() > 0 ? q[q.size()-3].tag : 0;
            t1 = q[q.size()-2].tag;
            t2 = q[q.size()-1].tag;
            foreach (q[i]) if (!q[i].done) begin
                if (q[i].tag != t0 && q[i].tag != t1 && q[i].tag != t2)
                    do_cmp(q[i].tag, 32'h55, 0, 0);
            end
            do_cmp(t1, 32'hE1, 1, 0);
            do_cmp(t0, 32'hE0, 0, 0);
            for (int i = 0; i < 4; i++) begin
                idle();
                alloc_valid = 1; alloc_pc = 32'h500; alloc_has_dst = 1; alloc_dst = 5'd20;
                cmp_valid = 1; cmp_tag = 3'(t2); cmp_value = 32'hE2;
                cycle();
            end
        end

        // Random traffic across full, wrap, flush and trap
        for (int c = 0; c < 6000; c++) begin
            idle();
            alloc_valid    = ($urandom_range(0, 99) < 60);
            alloc_pc       = $urandom;
            alloc_has_dst  = ($urandom_range(0, 99) < 80);
            alloc_dst      = 5'($urandom_range(0, 31));
            cmp_valid      = ($urandom_range(0, 99) < 55);
            cmp_tag        = 3'($urandom_range(0, 7));
            cmp_value      = $urandom;
            cmp_exc        = ($urandom_range(0, 99) < 3);
            cmp_mispredict = ($urandom_range(0, 99) < 6);
            cycle();
        end
        idle();
        do_idle(2);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule